// File: doc/BRIEF.md
# SPI Master Register and Word-FIFO Front End

This block is the bus-facing half of an SPI master. A processor reaches it through 32-bit word accesses in a 4 KiB window. It holds a control word, a configuration word, an interrupt-enable mask and a period word. It keeps a transmit queue and a receive queue of 32-bit words. A separate transfer engine does the serial shifting. It takes transmit words from this block over a valid/ready handshake and hands received words back the same way. This block also gives the engine a one-cycle start pulse when software asks for one.

The status word is mostly live. Five bits follow queue occupancy on every cycle. Two sticky bits record a receive overflow and the completion of a transfer, and software clears them by writing ones. A single level interrupt is raised whenever a status bit and its enable bit are both set. Writing the control word with the enable bit clear works as a full soft reset of the block.

Top module: `spi_regfront`

## Requirements
- R1: After reset the status word reads 0x00000003. Bit 0 (transmit queue empty) and bit 1 (transmit queue has space) are set. Every other register reads 0 and `irq` is low.
- R2: Status bits track queue occupancy every cycle. Bit 0 is transmit empty, bit 1 is transmit not full, bit 2 is transmit full, bit 3 is receive not empty and bit 4 is receive full.
- R3: The engine gets transmit words in write order. `eng_tx_valid` is high while the block is enabled and the transmit queue is not empty. `eng_tx_data` shows the oldest word, and a word is removed on a cycle where `eng_tx_valid` and `eng_tx_ready` are both high.
- R4: A write to the transmit data register is dropped while the block is disabled or while the transmit queue is full.
- R5: A read of the receive data register returns 0 while disabled and 0xDEADBEEF while the receive queue is empty. Otherwise it returns the oldest word and removes it. Read data appears on `bus_rdata` in the cycle after the read request.
- R6: A word offered by the engine while the receive queue is full is discarded and sets sticky status bit 5 (overflow). Words are not accepted while the block is disabled.
- R7: Sticky status bit 6 (transfer done) is set when the engine takes the last queued transmit word and no new word arrives in the same cycle.
- R8: A write to the status register clears bit 5 and bit 6 only where the written data has a 1 in that position. All other status bits ignore the write.
- R9: `irq` is high exactly when the bitwise AND of the status word and the interrupt-enable register is nonzero.
- R10: A write to the control register with bit 0 (enable) at 0 returns every register and both queues to their reset state.
- R11: A control write with bit 0 and bit 1 (start) both set gives `eng_start` a one-cycle pulse in the following cycle. Bit 1 is not stored and reads back as 0.
- R12: The word offsets are control 0x00, configuration 0x04, interrupt enable 0x08, status 0x0C, period 0x10, transmit data 0x14 and receive data 0x18. Offsets above 0x18 read 0 and ignore writes. The transmit data register reads 0, and a write to the receive data register has no effect.
- R13: The configuration, interrupt-enable and period registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 10 | Word address, byte offset bits 11..2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Level interrupt |
| eng_start | output | 1 | One-cycle start pulse to the transfer engine |
| eng_tx_valid | output | 1 | Transmit word available |
| eng_tx_ready | input | 1 | Engine takes the transmit word |
| eng_tx_data | output | 32 | Oldest transmit word |
| eng_rx_valid | input | 1 | Engine offers a received word |
| eng_rx_data | input | 32 | Received word |

## Verification
The queues are driven with short bursts of a few words, which show that order is kept and that the done flag waits for the last word. They are also driven with bursts one word longer than the depth, which show that the extra transmit word is dropped and that the extra receive word is discarded and raises overflow. Status writes use patterns that carry only the done bit, only the overflow bit, or all ones, which show which bits clear and which ignore the write. Accesses made while disabled, to offsets past the map, and to the receive data register by write are each followed by a status or data read-back, which shows that they changed nothing.

// File: rtl/spi_regfront_pkg.sv
// Shared constants for the SPI register front end.
// Assumes a 32-bit data path; register indices are word offsets.
package spi_regfront_pkg;
    localparam int REG_CTRL   = 0;
    localparam int REG_CFG    = 1;
    localparam int REG_IEN    = 2;
    localparam int REG_STAT   = 3;
    localparam int REG_PERIOD = 4;
    localparam int REG_TXD    = 5;
    localparam int REG_RXD    = 6;
    localparam int REG_COUNT  = 7;

    localparam int ST_TXE  = 0;
    localparam int ST_TXS  = 1;
    localparam int ST_TXF  = 2;
    localparam int ST_RXR  = 3;
    localparam int ST_RXF  = 4;
    localparam int ST_OVF  = 5;
    localparam int ST_DONE = 6;

    localparam int CTRL_EN = 0;
    localparam int CTRL_GO = 1;

    localparam logic [31:0] EMPTY_MARK = 32'hDEAD_BEEF;
endpackage

// File: rtl/spi_word_fifo.sv
// Word queue with occupancy count and synchronous clear.
// Assumes: a push while full and a pop while empty are ignored, and the
// head word is presented combinationally on rdata.
module spi_word_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Advance pointers and count; clear empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/spi_stat_irq.sv
// Status word assembly, sticky overflow/done bits and interrupt level.
// Assumes set and clear requests are single-cycle; a set wins over a
// write-one-to-clear in the same cycle, and clr wins over both.
module spi_stat_irq
    import spi_regfront_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tx_empty,
    input  logic          tx_full,
    input  logic          rx_empty,
    input  logic          rx_full,
    input  logic          ovf_set,
    input  logic          done_set,
    input  logic          w1c_ovf,
    input  logic          w1c_done,
    input  logic [DW-1:0] irq_en,
    output logic [DW-1:0] status,
    output logic          irq
);
    logic ovf_q, done_q;

    // Hold the sticky bits until software writes a one over them.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ovf_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (ovf_set)       ovf_q  <= 1'b1;
            else if (w1c_ovf)  ovf_q  <= 1'b0;
            if (done_set)      done_q <= 1'b1;
            else if (w1c_done) done_q <= 1'b0;
        end
    end

    // Build the status word from live occupancy and the sticky bits.
    always_comb begin
        status          = '0;
        status[ST_TXE]  = tx_empty;
        status[ST_TXS]  = !tx_full;
        status[ST_TXF]  = tx_full;
        status[ST_RXR]  = !rx_empty;
        status[ST_RXF]  = rx_full;
        status[ST_OVF]  = ovf_q;
        status[ST_DONE] = done_q;
    end

    // Raise the interrupt when any enabled status bit is set.
    assign irq = |(status & irq_en);

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_OVF] && !w1c_ovf && !clr) |=> status[ST_OVF]);

    assert_w1c_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_done && !done_set) |=> !status[ST_DONE]);
endmodule

// File: rtl/spi_regfront.sv
// Register decode and queue control for an SPI master front end.
// Assumes whole-word accesses only; bus_addr carries byte-offset bits
// 11..2. Read data is registered; a receive pop happens on the read cycle.
module spi_regfront
    import spi_regfront_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    parameter int AW    = 12,
    localparam int IW   = AW - 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:2] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          eng_start,
    output logic          eng_tx_valid,
    input  logic          eng_tx_ready,
    output logic [DW-1:0] eng_tx_data,
    input  logic          eng_rx_valid,
    input  logic [DW-1:0] eng_rx_data
);
    logic [DW-1:0] ctrl_q, cfg_q, ien_q, per_q, status, rx_head, rd_mux;
    logic [IW-1:0] idx;
    logic          enabled, ctrl_wr, soft_clr;
    logic          tx_push, tx_pop, tx_empty, tx_full;
    logic          rx_push, rx_pop, rx_empty, rx_full;
    logic          ovf_set, done_set, stat_wr;
    logic [CW-1:0] tx_cnt, rx_cnt;

    assign idx      = bus_addr;
    assign enabled  = ctrl_q[CTRL_EN];
    assign ctrl_wr  = bus_wr && (idx == IW'(REG_CTRL));
    assign soft_clr = ctrl_wr && !bus_wdata[CTRL_EN];
    assign stat_wr  = bus_wr && (idx == IW'(REG_STAT));

    assign tx_push      = bus_wr && (idx == IW'(REG_TXD)) && enabled;
    assign eng_tx_valid = enabled && !tx_empty;
    assign tx_pop       = eng_tx_valid && eng_tx_ready;
    assign done_set     = tx_pop && (tx_cnt == CW'(1)) && !tx_push;

    assign rx_push = eng_rx_valid && enabled;
    assign ovf_set = rx_push && rx_full;
    assign rx_pop  = bus_rd && (idx == IW'(REG_RXD)) && enabled;

    // Plain read/write registers; a disabling control write clears all.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
            ien_q  <= '0;
            per_q  <= '0;
        end else if (bus_wr) begin
            case (idx)
                IW'(REG_CTRL):   ctrl_q <= bus_wdata & ~(DW'(1) << CTRL_GO);
                IW'(REG_CFG):    cfg_q  <= bus_wdata;
                IW'(REG_IEN):    ien_q  <= bus_wdata;
                IW'(REG_PERIOD): per_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    // One-cycle start pulse after an enabling control write with start set.
    always_ff @(posedge clk) begin
        if (!rst_n) eng_start <= 1'b0;
        else        eng_start <= ctrl_wr && bus_wdata[CTRL_EN] && bus_wdata[CTRL_GO];
    end

    // Select the read value for the addressed word.
    always_comb begin
        case (idx)
            IW'(REG_CTRL):   rd_mux = ctrl_q;
            IW'(REG_CFG):    rd_mux = cfg_q;
            IW'(REG_IEN):    rd_mux = ien_q;
            IW'(REG_STAT):   rd_mux = status;
            IW'(REG_PERIOD): rd_mux = per_q;
            IW'(REG_RXD):    rd_mux = !enabled ? '0 : (rx_empty ? DW'(EMPTY_MARK) : rx_head);
            default:         rd_mux = '0;
        endcase
    end

    // Register the read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    spi_word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .push(tx_push), .wdata(bus_wdata), .pop(tx_pop), .rdata(eng_tx_data),
        .empty(tx_empty), .full(tx_full), .count(tx_cnt)
    );

    spi_word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .push(rx_push), .wdata(eng_rx_data), .pop(rx_pop), .rdata(rx_head),
        .empty(rx_empty), .full(rx_full), .count(rx_cnt)
    );

    spi_stat_irq #(.DW(DW)) u_stat (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
        .ovf_set(ovf_set), .done_set(done_set),
        .w1c_ovf(stat_wr && bus_wdata[ST_OVF]), .w1c_done(stat_wr && bus_wdata[ST_DONE]),
        .irq_en(ien_q), .status(status), .irq(irq)
    );

    assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    assert_tx_head_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_valid && !eng_tx_ready && !soft_clr) |=> (eng_tx_valid && $stable(eng_tx_data)));

    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (tx_cnt == '0 && rx_cnt == '0 && status == DW'(3) && !irq));

    assert_done_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_DONE]) |-> tx_empty);
endmodule

// File: tb/sim_spi_regfront.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares
// them against bus_rdata one cycle later.
module sim_spi_regfront;
    localparam int DEPTH = 64;
    localparam logic [11:0] A_CTRL = 12'h000, A_CFG = 12'h004, A_IEN = 12'h008,
                            A_STAT = 12'h00C, A_PER = 12'h010, A_TXD = 12'h014,
                            A_RXD = 12'h018, A_OOR = 12'h01C;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] bus_wdata = '0, eng_rx_data = '0;
    logic        eng_tx_ready = 1'b0, eng_rx_valid = 1'b0;
    logic [31:0] bus_rdata, eng_tx_data;
    logic        irq, eng_start, eng_tx_valid;

    int          n_vec = 0, n_bad = 0;
    bit          finished = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_pend = 1'b0;

    always #4 clk = ~clk;

    spi_regfront u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(addr[11:2]), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .eng_start(eng_start), .eng_tx_valid(eng_tx_valid),
        .eng_tx_ready(eng_tx_ready), .eng_tx_data(eng_tx_data),
        .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: compare registered read data against the scoreboard.
    always @(posedge clk) rd_pend <= bus_rd;
    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); bus_rd = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic take(input logic [31:0] e, input string tag);
        @(negedge clk);
        check({tag, " valid"}, {31'd0, eng_tx_valid}, 32'd1);
        check(tag, eng_tx_data, e);
        eng_tx_ready = 1'b1;
        @(negedge clk); eng_tx_ready = 1'b0;
    endtask

    task automatic give(input logic [31:0] d);
        @(negedge clk); eng_rx_valid = 1'b1; eng_rx_data = d;
        @(negedge clk); eng_rx_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_STAT, 32'h3, "R1 status");
        rd(A_CTRL, 32'h0, "R1 ctrl");
        rd(A_IEN, 32'h0, "R1 ien");
        check("R1 irq", {31'd0, irq}, 32'd0);
        // R12 map edges
        rd(A_OOR, 32'h0, "R12 out of range read");
        wr(A_OOR, 32'h5);
        rd(A_OOR, 32'h0, "R12 out of range write");
        rd(A_TXD, 32'h0, "R12 tx data reads 0");
        // R5/R4 while disabled
        rd(A_RXD, 32'h0, "R5 rx read disabled");
        wr(A_TXD, 32'h11);
        rd(A_STAT, 32'h3, "R4 tx write disabled");
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, 32'h1, "R12 ctrl enable");
        check("R4 no tx word", {31'd0, eng_tx_valid}, 32'd0);
        // R13 plain registers
        wr(A_CFG, 32'hA5A5_0F0F);
        rd(A_CFG, 32'hA5A5_0F0F, "R13 cfg");
        wr(A_PER, 32'h0000_1234);
        rd(A_PER, 32'h0000_1234, "R13 period");
        // R3 order, R2 status, R7 done
        for (int i = 0; i < 3; i++) wr(A_TXD, 32'hC0DE_0000 + i);
        rd(A_STAT, 32'h2, "R2 tx partly filled");
        take(32'hC0DE_0000, "R3 word0");
        take(32'hC0DE_0001, "R3 word1");
        rd(A_STAT, 32'h2, "R7 not done yet");
        take(32'hC0DE_0002, "R3 word2");
        rd(A_STAT, 32'h43, "R7 done set");
        check("R3 valid low when empty", {31'd0, eng_tx_valid}, 32'd0);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, 32'h3, "R8 clear all ones");
        // R5 receive path
        give(32'hAAAA_0001);
        give(32'hAAAA_0002);
        rd(A_STAT, 32'h0B, "R2 rx ready");
        rd(A_RXD, 32'hAAAA_0001, "R5 rx word1");
        rd(A_RXD, 32'hAAAA_0002, "R5 rx word2");
        rd(A_RXD, 32'hDEAD_BEEF, "R5 rx empty marker");
        rd(A_STAT, 32'h3, "R2 rx drained");
        wr(A_RXD, 32'h77);
        rd(A_STAT, 32'h3, "R12 rx write ignored");
        rd(A_RXD, 32'hDEAD_BEEF, "R12 rx write no data");
        // R6 overflow
        for (int i = 0; i <= DEPTH; i++) give(32'hBB00_0000 + i);
        rd(A_STAT, 32'h3B, "R6 full and overflow");
        wr(A_STAT, 32'h40);
        rd(A_STAT, 32'h3B, "R8 done-only write keeps overflow");
        for (int i = 0; i < DEPTH; i++) rd(A_RXD, 32'hBB00_0000 + i, "R6 rx order");
        rd(A_RXD, 32'hDEAD_BEEF, "R6 extra word discarded");
        rd(A_STAT, 32'h23, "R6 overflow sticky");
        wr(A_STAT, 32'h20);
        rd(A_STAT, 32'h3, "R8 overflow cleared");
        // R9 interrupt
        wr(A_IEN, 32'h1);
        check("R9 irq tx empty", {31'd0, irq}, 32'd1);
        wr(A_IEN, 32'h40);
        check("R9 irq masked", {31'd0, irq}, 32'd0);
        wr(A_TXD, 32'h5150_0000);
        take(32'h5150_0000, "R3 single word");
        check("R9 irq on done", {31'd0, irq}, 32'd1);
        wr(A_STAT, 32'h40);
        check("R9 irq after clear", {31'd0, irq}, 32'd0);
        // R4 full transmit queue
        for (int i = 0; i <= DEPTH; i++) wr(A_TXD, 32'hDD00_0000 + i);
        rd(A_STAT, 32'h04, "R2 tx full");
        for (int i = 0; i < DEPTH; i++) take(32'hDD00_0000 + i, "R4 tx order");
        check("R4 extra word dropped", {31'd0, eng_tx_valid}, 32'd0);
        rd(A_STAT, 32'h43, "R7 done after full drain");
        wr(A_STAT, 32'h40);
        // R11 start pulse
        wr(A_CTRL, 32'h3);
        check("R11 start high", {31'd0, eng_start}, 32'd1);
        @(negedge clk);
        check("R11 start one cycle", {31'd0, eng_start}, 32'd0);
        rd(A_CTRL, 32'h1, "R11 start not stored");
        wr(A_CTRL, 32'h1);
        check("R11 no start without bit", {31'd0, eng_start}, 32'd0);
        // R10 soft reset
        wr(A_IEN, 32'h1);
        wr(A_TXD, 32'h99);
        give(32'h55);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, 32'h0, "R10 ctrl");
        rd(A_IEN, 32'h0, "R10 ien");
        rd(A_CFG, 32'h0, "R10 cfg");
        rd(A_PER, 32'h0, "R10 period");
        rd(A_STAT, 32'h3, "R10 status");
        check("R10 irq", {31'd0, irq}, 32'd0);
        wr(A_CTRL, 32'h1);
        rd(A_STAT, 32'h3, "R10 queues empty");
        rd(A_RXD, 32'hDEAD_BEEF, "R10 rx flushed");
        check("R10 tx flushed", {31'd0, eng_tx_valid}, 32'd0);
        repeat (2) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule